// File: doc/BRIEF.md
# Per-Pin Edge and Level Event Detector

This block watches a bank of already-synchronized pin inputs and turns selected activity on each pin into a sticky status flag. Each pin has its own 4-bit mode code. The code picks the condition to detect, which is a rising edge, a falling edge, either edge, a low level or a high level. It also picks whether the resulting flag is routed to the shared interrupt line or to that pin's DMA request line.

Software reaches the block through a simple word-addressed register port. Each pin has a control word at byte offset 4*n. That word holds the mode in bits [19:16] and the pin's flag in bit 24. A summary word at byte offset 0xA0 shows all flags, with bit n for pin n. A flag can be cleared by writing 1 to it in either location. A flag raised in a DMA mode also clears itself when the DMA engine reports completion for that pin.

Edges are found by comparing each pin with a registered copy taken one cycle earlier. After reset, and after any change to a pin's mode, the first cycle reports no edge. This keeps a stale history sample from producing a false event.

Top module: `pin_event_detector`

## Requirements
- R1: After reset all flags, all mode fields, `irq`, `dma_req` and every register read are 0.
- R2: Mode 1001 sets the pin's flag on a rising edge, 1010 on a falling edge and 1011 on either edge. The flag is visible in summary bit n and in bit 24 of the pin's word one cycle after the edge is sampled.
- R3: Mode 0001 sets the flag on a rising edge, 0010 on a falling edge and 0011 on either edge. In these modes `dma_req[n]` follows the flag and the flag does not drive `irq`.
- R4: Mode 1100 sets the flag in every cycle the pin is 1, and mode 1000 does so in every cycle the pin is 0.
- R5: Writing 1 to summary bit n (offset 0xA0), or to bit 24 of the word at offset 4*n, clears flag n. Writing 0 there leaves it unchanged. A write to offset 4*n loads bits [19:16] as the mode.
- R6: In modes 0001 to 0011 a pulse on `dma_done[n]` clears flag n. In any other mode `dma_done[n]` has no effect.
- R7: In a level mode whose level is still present, a software clear leaves the flag set.
- R8: The cycle after reset, and the cycle after a write that changes a pin's mode, report no edge for that pin.
- R9: Mode 0000 and every code not listed in R2 to R4 detect nothing.
- R10: `irq` is the OR of the flags of all pins in modes 1000 to 1100. Flags of pins in DMA modes do not contribute.
- R11: When an event and a clear for the same pin fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| dma_done | input | NUM_PINS | Per-pin transfer-complete pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt |
| dma_req | output | NUM_PINS | Per-pin DMA request |

## Verification
The in-line assertions check several rules on every cycle. An armed edge in a matching mode sets its flag. An active level keeps its flag set even against a software clear. A flag holds while nothing clears it. `dma_done` clears a DMA-mode flag. A disarmed pin in an edge mode never gains a flag. Other behaviours depend on sequences of register traffic, and only the bench scenarios can show them. These include routing through the two clear locations, `dma_done` being ignored outside DMA modes, suppression of an edge that coincides with a mode change, unlisted codes doing nothing, and the interrupt OR across several pins.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  localparam int MODE_W     = 4;
  localparam int MODE_LSB   = 16;
  localparam int FLAG_BIT   = 24;
  localparam int PIN_STRIDE = 4;
  localparam int SUM_OFFSET = 'hA0;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF      = 4'b0000,
    MD_DMA_RISE = 4'b0001,
    MD_DMA_FALL = 4'b0010,
    MD_DMA_BOTH = 4'b0011,
    MD_INT_LOW  = 4'b1000,
    MD_INT_RISE = 4'b1001,
    MD_INT_FALL = 4'b1010,
    MD_INT_BOTH = 4'b1011,
    MD_INT_HIGH = 4'b1100
  } mode_e;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic on_high;
    logic on_low;
    logic is_dma;
    logic is_int;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(logic [MODE_W-1:0] code);
    mode_dec_t d;
    d = '0;
    case (code)
      MD_DMA_RISE: begin d.on_rise = 1'b1; d.is_dma = 1'b1; end
      MD_DMA_FALL: begin d.on_fall = 1'b1; d.is_dma = 1'b1; end
      MD_DMA_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.is_dma = 1'b1; end
      MD_INT_LOW:  begin d.on_low  = 1'b1; d.is_int = 1'b1; end
      MD_INT_RISE: begin d.on_rise = 1'b1; d.is_int = 1'b1; end
      MD_INT_FALL: begin d.on_fall = 1'b1; d.is_int = 1'b1; end
      MD_INT_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.is_int = 1'b1; end
      MD_INT_HIGH: begin d.on_high = 1'b1; d.is_int = 1'b1; end
      default:     d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pin_evt_regs.sv
module pin_evt_regs
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_PINS-1:0]              flags_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [NUM_PINS-1:0][MODE_W-1:0]  mode_o,
  output logic [NUM_PINS-1:0]              mode_chg_o,
  output logic [NUM_PINS-1:0]              sw_clr_o
);
  localparam logic [ADDR_W-1:0] SUM_ADDR = ADDR_W'(SUM_OFFSET);

  logic [NUM_PINS-1:0][MODE_W-1:0] mode_q, mode_d;
  logic [NUM_PINS-1:0]             mode_en;
  logic                            sum_wr;
  logic [MODE_W-1:0]               wr_mode;

  assign sum_wr  = wr_i && (addr_i == SUM_ADDR);
  assign wr_mode = wdata_i[MODE_LSB +: MODE_W];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_reg
    logic sel;
    assign sel           = wr_i && (addr_i == ADDR_W'(PIN_STRIDE * g));
    assign mode_en[g]    = sel;
    assign mode_chg_o[g] = sel && (wr_mode != mode_q[g]);
    assign sw_clr_o[g]   = (sel && wdata_i[FLAG_BIT]) || (sum_wr && wdata_i[g]);

    always_comb begin
      mode_d[g] = mode_q[g];
      if (mode_en[g]) mode_d[g] = wr_mode;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         mode_q[g] <= '0;
      else if (mode_en[g]) mode_q[g] <= mode_d[g];
    end
  end

  assign mode_o = mode_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == SUM_ADDR) rdata_o[NUM_PINS-1:0] = flags_i;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr_i == ADDR_W'(PIN_STRIDE * i)) begin
        rdata_o[FLAG_BIT]            = flags_i[i];
        rdata_o[MODE_LSB +: MODE_W]  = mode_q[i];
      end
    end
  end
endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
  import pin_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              mode_chg_i,
  input  logic              sw_clr_i,
  input  logic              dma_done_i,
  output logic              flag_o,
  output logic              irq_src_o,
  output logic              dma_req_o
);
  mode_dec_t dec;
  logic prev_q, prev_d;
  logic arm_q, arm_d;
  logic flag_q, flag_d, flag_en;
  logic rise_ev, fall_ev, lvl_ev, hit, auto_clr;

  always_comb begin
    dec      = decode_mode(mode_i);
    rise_ev  = dec.on_rise & arm_q & pin_i & ~prev_q;
    fall_ev  = dec.on_fall & arm_q & ~pin_i & prev_q;
    lvl_ev   = (dec.on_high & pin_i) | (dec.on_low & ~pin_i);
    hit      = rise_ev | fall_ev | lvl_ev;
    auto_clr = dec.is_dma & dma_done_i;
    prev_d   = pin_i;
    arm_d    = ~mode_chg_i;
    flag_en  = hit | sw_clr_i | auto_clr;
    flag_d   = hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      arm_q  <= arm_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o    = flag_q;
  assign irq_src_o = flag_q & dec.is_int;
  assign dma_req_o = flag_q & dec.is_dma;

  AST_ARMED_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.on_rise && arm_q && pin_i && !prev_q) |=> flag_q); // R2
  AST_LEVEL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dec.on_high && pin_i) || (dec.on_low && !pin_i)) |=> flag_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !sw_clr_i && !(dec.is_dma && dma_done_i)) |=> flag_q); // R5
  AST_DMA_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.is_dma && dma_done_i && !arm_q) |=> !flag_q); // R6
  AST_NO_EDGE_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_q && !flag_q && !dec.on_high && !dec.on_low) |=> !flag_q); // R8
endmodule

// File: rtl/pin_evt_merge.sv
module pin_evt_merge #(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] irq_src_i,
  output logic                irq_o
);
  assign irq_o = |irq_src_i;
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] dma_done,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq,
  output logic [NUM_PINS-1:0] dma_req
);
  logic                            rst_meta_q, rst_sync_q;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode;
  logic [NUM_PINS-1:0]             mode_chg, sw_clr, flags, irq_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pin_evt_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk), .rst_ni(rst_sync_q), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .flags_i(flags), .rdata_o(reg_rdata),
    .mode_o(mode), .mode_chg_o(mode_chg), .sw_clr_o(sw_clr)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cell
    pin_evt_cell u_cell (
      .clk_i(clk), .rst_ni(rst_sync_q), .pin_i(pin_in[g]), .mode_i(mode[g]),
      .mode_chg_i(mode_chg[g]), .sw_clr_i(sw_clr[g]), .dma_done_i(dma_done[g]),
      .flag_o(flags[g]), .irq_src_o(irq_src[g]), .dma_req_o(dma_req[g])
    );
  end

  pin_evt_merge #(.NUM_PINS(NUM_PINS)) u_merge (.irq_src_i(irq_src), .irq_o(irq));

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |=> (flags == '0 || !rst_sync_q)); // R1
  AST_DMA_NOT_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ((dma_req == flags) && (flags != '0)) |-> !irq); // R10
endmodule

// File: tb/pin_event_detector_bench.sv
`timescale 1ns/1ps
module pin_event_detector_bench;
  localparam int NP = 32;
  localparam logic [7:0] SUM = 8'hA0;

  logic        clk;
  logic        rst_n;
  logic [NP-1:0] pins, done;
  logic        wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic [NP-1:0] dreq;

  int checks = 0;
  int errors = 0;
  bit started = 0;

  pin_event_detector u_pin_event_detector (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .dma_done(done), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .dma_req(dreq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference model
  int      m_mode [NP];
  bit      m_flag [NP];
  bit      m_prev [NP];
  bit      m_arm  [NP];
  int      rcnt;

  function automatic bit is_dma_mode(int md);
    return (md >= 1 && md <= 3);
  endfunction
  function automatic bit is_int_mode(int md);
    return (md == 8 || md == 9 || md == 10 || md == 11 || md == 12);
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      rcnt = 0;
      for (int i = 0; i < NP; i++) begin
        m_mode[i] = 0; m_flag[i] = 0; m_prev[i] = 0; m_arm[i] = 0;
      end
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      for (int i = 0; i < NP; i++) begin
        bit r, f, ev, clr, sel;
        int nm;
        r  = m_arm[i] && pins[i] && !m_prev[i];
        f  = m_arm[i] && !pins[i] && m_prev[i];
        ev = 0;
        case (m_mode[i])
          1, 9:   ev = r;
          2, 10:  ev = f;
          3, 11:  ev = r || f;
          8:      ev = !pins[i];
          12:     ev = pins[i];
          default: ev = 0;
        endcase
        sel = wr && (int'(addr) == i * 4);
        clr = (wr && addr == SUM && wdata[i]) || (sel && wdata[24]) ||
              (is_dma_mode(m_mode[i]) && done[i]);
        m_flag[i] = ev || (m_flag[i] && !clr);
        nm = sel ? int'(wdata[19:16]) : m_mode[i];
        m_arm[i]  = !(sel && nm != m_mode[i]);
        m_mode[i] = nm;
        m_prev[i] = pins[i];
      end
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == SUM) for (int i = 0; i < NP; i++) v[i] = m_flag[i];
    else if (a[1:0] == 2'b00 && (a >> 2) < NP) begin
      v[24]    = m_flag[a >> 2];
      v[19:16] = 4'(m_mode[a >> 2]);
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      logic ei;
      logic [NP-1:0] ed;
      ei = 0; ed = '0;
      for (int i = 0; i < NP; i++) begin
        if (m_flag[i] && is_int_mode(m_mode[i])) ei = 1;
        ed[i] = m_flag[i] && is_dma_mode(m_mode[i]);
      end
      chk("R10 irq vs model", {31'b0, irq}, {31'b0, ei});
      chk("R3 dma_req vs model", dreq, ed);
      chk("R5 read vs model", rdata, model_read(addr));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wreg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1; wr = 1; addr = a; wdata = d;
    @(negedge clk); #1; wr = 0; wdata = '0;
  endtask
  task automatic setpin(int i, logic v);
    @(negedge clk); #1; pins[i] = v;
  endtask
  task automatic pulse_done(int i);
    @(negedge clk); #1; done[i] = 1'b1;
    @(negedge clk); #1; done[i] = 1'b0;
  endtask
  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); #1; addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; pins = '0; done = '0; wr = 0; addr = '0; wdata = '0;
    cyc(4);
    chk("R1 irq in reset", {31'b0, irq}, 32'd0);
    #1 rst_n = 1;
    cyc(4);
    rd_chk("R1 summary after reset", SUM, 32'd0);
    rd_chk("R1 pin5 word after reset", 8'h14, 32'd0);
    chk("R1 dma_req after reset", dreq, 32'd0);

    // R9: off and unlisted codes
    wreg(8'h00, 32'h0000_0000);
    wreg(8'h04, 32'h0005_0000);
    cyc(2);
    setpin(0, 1); setpin(1, 1); cyc(1);
    setpin(0, 0); setpin(1, 0); cyc(1);
    rd_chk("R9 no flags in off/unlisted mode", SUM, 32'd0);
    rd_chk("R9 unlisted code stored", 8'h04, 32'h0005_0000);

    // R2: interrupt edge modes
    wreg(8'h08, 32'h0009_0000); cyc(2);
    setpin(2, 1);
    rd_chk("R2 rise sets flag", SUM, 32'h4);
    chk("R10 irq from rise", {31'b0, irq}, 32'd1);
    rd_chk("R2 flag in pin word bit24", 8'h08, 32'h0109_0000);
    setpin(2, 0);
    wreg(SUM, 32'h4);
    rd_chk("R5 summary clear", SUM, 32'd0);
    chk("R10 irq drops", {31'b0, irq}, 32'd0);
    wreg(8'h0C, 32'h000A_0000); cyc(2);
    setpin(3, 1);
    rd_chk("R2 fall mode ignores rise", SUM, 32'd0);
    setpin(3, 0);
    rd_chk("R2 fall sets flag", SUM, 32'h8);
    wreg(8'h0C, 32'h010A_0000);
    rd_chk("R5 pin-word clear", SUM, 32'd0);
    wreg(8'h10, 32'h000B_0000); cyc(2);
    setpin(4, 1);
    rd_chk("R2 both: rise", SUM, 32'h10);
    wreg(SUM, 32'h10);
    setpin(4, 0);
    rd_chk("R2 both: fall", SUM, 32'h10);
    wreg(SUM, 32'h10);
    rd_chk("R5 cleared pin4", SUM, 32'd0);

    // R3 / R6: DMA modes
    wreg(8'h18, 32'h0001_0000); cyc(2);
    setpin(6, 1);
    rd_chk("R3 dma rise sets flag", SUM, 32'h40);
    chk("R3 dma_req follows flag", dreq, 32'h40);
    chk("R3 no irq from dma pin", {31'b0, irq}, 32'd0);
    pulse_done(6);
    rd_chk("R6 dma_done clears flag", SUM, 32'd0);
    chk("R6 dma_req drops", dreq, 32'd0);
    setpin(6, 0);
    setpin(2, 1);
    pulse_done(2);
    rd_chk("R6 dma_done ignored in irq mode", SUM, 32'h4);
    wreg(SUM, 32'h4);

    // R4 / R7: level modes
    wreg(8'h1C, 32'h000C_0000); cyc(1);
    rd_chk("R4 high level absent", SUM, 32'd0);
    setpin(7, 1);
    rd_chk("R4 high level sets", SUM, 32'h80);
    wreg(8'h1C, 32'h010C_0000);
    rd_chk("R7 clear while level held", SUM, 32'h80);
    setpin(7, 0);
    wreg(8'h1C, 32'h010C_0000);
    rd_chk("R7 clear after level gone", SUM, 32'd0);
    wreg(8'h20, 32'h0008_0000);
    rd_chk("R4 low level sets", SUM, 32'h100);
    setpin(8, 1);
    wreg(SUM, 32'h100);
    rd_chk("R4 low level cleared when high", SUM, 32'd0);

    // R5: zero writes have no effect
    setpin(2, 0); setpin(2, 1);
    wreg(SUM, 32'h0);
    rd_chk("R5 zero write to summary", SUM, 32'h4);
    wreg(8'h08, 32'h0009_0000);
    rd_chk("R5 zero bit24 in pin word", SUM, 32'h4);
    wreg(SUM, 32'h4);

    // R8: edge coinciding with mode change is dropped
    @(negedge clk); #1; wr = 1; addr = 8'h24; wdata = 32'h0009_0000;
    @(negedge clk); #1; wr = 0; wdata = '0; pins[9] = 1'b1;
    rd_chk("R8 no edge right after mode change", SUM, 32'd0);
    setpin(9, 0); setpin(9, 1);
    rd_chk("R8 later edge detected", SUM, 32'h200);
    wreg(SUM, 32'h200);

    // R11: event and clear in the same cycle
    setpin(2, 0); setpin(2, 1); setpin(2, 0);
    @(negedge clk); #1; wr = 1; addr = SUM; wdata = 32'h4; pins[2] = 1'b1;
    @(negedge clk); #1; wr = 0; wdata = '0;
    rd_chk("R11 event beats clear", SUM, 32'h4);

    // R10: OR over interrupt pins only
    setpin(4, 1);
    rd_chk("R10 two irq flags", SUM, 32'h14);
    wreg(SUM, 32'h4); #1;
    chk("R10 irq held by remaining flag", {31'b0, irq}, 32'd1);
    wreg(SUM, 32'h10); #1;
    chk("R10 irq low when all clear", {31'b0, irq}, 32'd0);
    setpin(6, 1); cyc(1); #1;
    chk("R10 dma flag not on irq", {31'b0, irq}, 32'd0);
    chk("R3 dma_req for pin6", dreq, 32'h40);
    pulse_done(6);
    cyc(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule